// File: doc/BRIEF.md
# Interrupt Distributor State Register Bank

This block keeps the per-interrupt state behind a memory-mapped register port for `NUM_IRQ` interrupt lines. Every line has an enable bit, a pending bit, an active bit, a stored priority and a trigger type. Software reaches this state through paired set and clear views. A read of either view returns the current state. On a write, a 1 in a data bit sets the state (set view) or clears it (clear view). The priority view has one byte per interrupt. The configuration view has a two-bit field per interrupt.

Pending state depends on the trigger type. A level-sensitive line is pending while its sampled source level is high or while a software latch is set. The latch is set by a set-pending write and cleared by a clear-pending write. An edge-triggered line has a sticky pending flag. A rising edge of its source or a set-pending write sets the flag, and a clear-pending write clears it. The per-interrupt outputs go to a downstream arbiter.

Byte map (12-bit offset): enable-set 0x000, enable-clear 0x080, pending-set 0x100, pending-clear 0x180, active-set 0x200, active-clear 0x280 (each 0x80 bytes). Priority is at 0x400 (0x400 bytes). Configuration is at 0xC00 (0x100 bytes). All other offsets are unmapped.

Top module: `irq_dist_regbank`

## Requirements
- R1: In the enable views, byte offset `o` bit `b` maps to interrupt `o*8+b`. Both views read back the enable bits. A 1 written to the set view enables that interrupt, and a 1 written to the clear view disables it.
- R2: In all set and clear views, data bits that are 0 leave the state unchanged.
- R3: A set-pending write to a level-sensitive interrupt sets its software latch, so the interrupt stays pending after its source level goes low.
- R4: A clear-pending write to a level-sensitive interrupt clears the latch, so pending then follows the sampled source level. The same write to an edge-triggered interrupt clears pending.
- R5: For an edge-triggered interrupt, a rising edge on `line_i` sets pending one clock later. Pending stays set after the line falls.
- R6: Active-set and active-clear writes set and clear active bits (interrupt `o*8+b`). A set write to an interrupt that is already active changes nothing.
- R7: Priority byte offset `o` is interrupt `o`. Only the upper `PRIO_BITS` bits (default 5) are stored. The lower bits read as 0 and are 0 on `prio_o`.
- R8: Configuration byte offset `o` holds interrupts `4o..4o+3`, two bits each (interrupt `4o+f` at bits `2f+1:2f`). Bit `2f+1` set selects edge, so a field reads 2 for edge and 0 for level. Writes to interrupts 0..31 are ignored, and those interrupts stay level-sensitive.
- R9: An interrupt switched from edge to level has pending equal to the source level OR its software latch. The latch is kept through edge-mode clears.
- R10: Interrupts at or above `NUM_IRQ`, and unmapped offsets, read as 0. Writes to them change no state.
- R11: `word_i`=1 selects a 32-bit access, which must be 4-byte aligned. A misaligned word access reads 0 and writes nothing. `word_i`=0 selects a byte access that uses data bits 7:0. Read data appears on `rdata_o` one clock after `re_i`.
- R12: After reset all bits are 0: disabled, not pending, not active, priority 0, level-sensitive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| addr_i | input | 12 | Byte offset |
| word_i | input | 1 | 1: 32-bit access, 0: byte access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| line_i | input | NUM_IRQ | Source levels |
| enable_o | output | NUM_IRQ | Enable bits |
| pending_o | output | NUM_IRQ | Pending bits |
| active_o | output | NUM_IRQ | Active bits |
| edge_o | output | NUM_IRQ | 1 = edge-triggered |
| prio_o | output | NUM_IRQ*8 | Priority, 8 bits per interrupt |

## Verification
The bench targets the interaction between the software latch and the live line level. A design without the latch would drop a level interrupt when its line falls. A design that clears pending outright on a level clear-pending write would lose a line that is still high. The bench switches one interrupt from level to edge and back, with clears in between. This catches a latch that is dropped during edge mode, and a pending flag that is lost on the switch. It also writes configuration to the private range, reads priority lanes for truncation, and checks byte lanes, misaligned accesses and out-of-range IDs. A design that got these wrong would show edge behaviour on locked IDs, set priority bits that are not implemented, or corrupt state through an access that should be ignored.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int ADDR_W = 12;
  localparam int OFF_W  = 10;

  typedef enum logic [3:0] {
    RG_NONE, RG_EN_SET, RG_EN_CLR, RG_PD_SET, RG_PD_CLR,
    RG_AC_SET, RG_AC_CLR, RG_PRIO, RG_CFG
  } region_e;

  // {hit, lane} for a region-relative byte index against the current access
  function automatic logic [2:0] lane_sel(input logic [OFF_W-1:0] idx,
                                          input logic [OFF_W-1:0] off,
                                          input logic             word);
    if (word) return {idx[OFF_W-1:2] == off[OFF_W-1:2], idx[1:0]};
    return {idx == off, 2'b00};
  endfunction
endpackage

// File: rtl/irq_dist_decode.sv
module irq_dist_decode
  import irq_dist_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              word_i,
  output region_e           region_o,
  output logic [OFF_W-1:0]  off_o,
  output logic              ok_o
);
  always_comb begin
    region_o = RG_NONE;
    off_o    = '0;
    if (addr_i[11:10] == 2'b00) begin
      off_o = {3'b000, addr_i[6:0]};
      unique case (addr_i[9:7])
        3'd0:    region_o = RG_EN_SET;
        3'd1:    region_o = RG_EN_CLR;
        3'd2:    region_o = RG_PD_SET;
        3'd3:    region_o = RG_PD_CLR;
        3'd4:    region_o = RG_AC_SET;
        3'd5:    region_o = RG_AC_CLR;
        default: region_o = RG_NONE;
      endcase
    end else if (addr_i[11:10] == 2'b01) begin
      region_o = RG_PRIO;
      off_o    = addr_i[9:0];
    end else if (addr_i[11:8] == 4'hC) begin
      region_o = RG_CFG;
      off_o    = {2'b00, addr_i[7:0]};
    end
  end

  assign ok_o = !(word_i && (addr_i[1:0] != 2'b00));
endmodule

// File: rtl/irq_dist_cell.sv
module irq_dist_cell #(
  parameter int PRIO_BITS  = 5,
  parameter bit LOCKED_CFG = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 line_i,
  input  logic                 en_set_i,
  input  logic                 en_clr_i,
  input  logic                 pd_set_i,
  input  logic                 pd_clr_i,
  input  logic                 ac_set_i,
  input  logic                 ac_clr_i,
  input  logic                 prio_we_i,
  input  logic [PRIO_BITS-1:0] prio_wd_i,
  input  logic                 cfg_we_i,
  input  logic                 cfg_edge_i,
  output logic                 enable_o,
  output logic                 pending_o,
  output logic                 active_o,
  output logic                 edge_o,
  output logic [PRIO_BITS-1:0] prio_o
);
  logic line_q, soft_q, pend_q, en_q, act_q, edge_q;
  logic [PRIO_BITS-1:0] prio_q;
  logic rise, cfg_we;

  assign rise   = line_i & ~line_q;
  assign cfg_we = cfg_we_i & ~LOCKED_CFG;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
      soft_q <= 1'b0;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      act_q  <= 1'b0;
      edge_q <= 1'b0;
      prio_q <= '0;
    end else begin
      line_q <= line_i;
      if (en_set_i)      en_q <= 1'b1;
      else if (en_clr_i) en_q <= 1'b0;
      if (ac_set_i)      act_q <= 1'b1;
      else if (ac_clr_i) act_q <= 1'b0;
      if (prio_we_i)     prio_q <= prio_wd_i;
      if (!edge_q) begin
        if (pd_set_i)      soft_q <= 1'b1;
        else if (pd_clr_i) soft_q <= 1'b0;
      end
      if (cfg_we) edge_q <= cfg_edge_i;
      // level to edge: keep whatever is pending now
      if (cfg_we && cfg_edge_i && !edge_q) pend_q <= line_q | soft_q;
      else if (edge_q) begin
        if (rise || pd_set_i) pend_q <= 1'b1;
        else if (pd_clr_i)    pend_q <= 1'b0;
      end
    end
  end

  assign enable_o  = en_q;
  assign active_o  = act_q;
  assign edge_o    = edge_q;
  assign prio_o    = prio_q;
  assign pending_o = edge_q ? pend_q : (line_q | soft_q);

  p_en_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_set_i |=> enable_o);
  p_en_clr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_clr_i && !en_set_i) |=> !enable_o);
  p_lvl_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_set_i && !edge_o && !cfg_we_i) |=> pending_o);
  p_lvl_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_clr_i && !pd_set_i && !edge_o && !cfg_we_i) |=> (pending_o == $past(line_i)));
  p_edge_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_clr_i && !pd_set_i && edge_o && !rise && !cfg_we_i) |=> !pending_o);
  p_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && line_i && !line_q && !cfg_we_i) |=> pending_o);
  p_act_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ac_set_i |=> active_o);
  p_cfg_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && LOCKED_CFG) |=> $stable(edge_o));
endmodule

// File: rtl/irq_dist_rdmux.sv
module irq_dist_rdmux
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic [NUM_IRQ-1:0]   enable_i,
  input  logic [NUM_IRQ-1:0]   pending_i,
  input  logic [NUM_IRQ-1:0]   active_i,
  input  logic [NUM_IRQ-1:0]   edge_i,
  input  logic [NUM_IRQ*8-1:0] prio_i,
  input  region_e              region_i,
  input  logic [OFF_W-1:0]     off_i,
  input  logic                 word_i,
  input  logic                 ok_i,
  output logic [31:0]          rdata_o
);
  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [OFF_W-1:0] b;
    logic [7:0]       v;
    logic [3:0]       e4;

    assign b = word_i ? {off_i[OFF_W-1:2], 2'(k)} : off_i;

    // shifting past the vector end yields zero for out-of-range IDs
    always_comb begin
      v  = '0;
      e4 = 4'(edge_i >> {b, 2'b00});
      case (region_i)
        RG_EN_SET, RG_EN_CLR: v = 8'(enable_i  >> {b, 3'b000});
        RG_PD_SET, RG_PD_CLR: v = 8'(pending_i >> {b, 3'b000});
        RG_AC_SET, RG_AC_CLR: v = 8'(active_i  >> {b, 3'b000});
        RG_PRIO:              v = 8'(prio_i    >> {b, 3'b000});
        RG_CFG:               v = {e4[3], 1'b0, e4[2], 1'b0, e4[1], 1'b0, e4[0], 1'b0};
        default:              v = '0;
      endcase
    end

    assign rdata_o[k*8 +: 8] = (ok_i && (word_i || k == 0)) ? v : 8'h00;
  end
endmodule

// File: rtl/irq_dist_regbank.sv
module irq_dist_regbank
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int PRIO_BITS = 5,
  parameter int NUM_PRIV  = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic                 re_i,
  input  logic [11:0]          addr_i,
  input  logic                 word_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NUM_IRQ-1:0]   line_i,
  output logic [NUM_IRQ-1:0]   enable_o,
  output logic [NUM_IRQ-1:0]   pending_o,
  output logic [NUM_IRQ-1:0]   active_o,
  output logic [NUM_IRQ-1:0]   edge_o,
  output logic [NUM_IRQ*8-1:0] prio_o
);
  localparam int PAD = 8 - PRIO_BITS;

  region_e          region;
  logic [OFF_W-1:0] off;
  logic             ok, wr;
  logic [31:0]      rd_comb;
  logic [31:0]      rdata_q;

  irq_dist_decode u_dec (
    .addr_i   (addr_i),
    .word_i   (word_i),
    .region_o (region),
    .off_o    (off),
    .ok_o     (ok)
  );

  assign wr = we_i & ok;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    logic [2:0]           ls_bit, ls_pr, ls_cf;
    logic                 hit_bit, dbit;
    logic [7:0]           pbyte;
    logic [PRIO_BITS-1:0] prio_q;

    assign ls_bit  = lane_sel(OFF_W'(i / 8), off, word_i);
    assign ls_pr   = lane_sel(OFF_W'(i), off, word_i);
    assign ls_cf   = lane_sel(OFF_W'(i / 4), off, word_i);
    assign hit_bit = wr & ls_bit[2];
    assign dbit    = wdata_i[{ls_bit[1:0], 3'(i % 8)}];
    assign pbyte   = 8'(wdata_i >> {ls_pr[1:0], 3'b000});

    irq_dist_cell #(
      .PRIO_BITS  (PRIO_BITS),
      .LOCKED_CFG (i < NUM_PRIV)
    ) u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .line_i     (line_i[i]),
      .en_set_i   (hit_bit && dbit && region == RG_EN_SET),
      .en_clr_i   (hit_bit && dbit && region == RG_EN_CLR),
      .pd_set_i   (hit_bit && dbit && region == RG_PD_SET),
      .pd_clr_i   (hit_bit && dbit && region == RG_PD_CLR),
      .ac_set_i   (hit_bit && dbit && region == RG_AC_SET),
      .ac_clr_i   (hit_bit && dbit && region == RG_AC_CLR),
      .prio_we_i  (wr && ls_pr[2] && region == RG_PRIO),
      .prio_wd_i  (pbyte[7 -: PRIO_BITS]),
      .cfg_we_i   (wr && ls_cf[2] && region == RG_CFG),
      .cfg_edge_i (wdata_i[{ls_cf[1:0], 3'(2 * (i % 4) + 1)}]),
      .enable_o   (enable_o[i]),
      .pending_o  (pending_o[i]),
      .active_o   (active_o[i]),
      .edge_o     (edge_o[i]),
      .prio_o     (prio_q)
    );

    if (PAD > 0) begin : g_pad
      assign prio_o[i*8 +: 8] = {prio_q, {PAD{1'b0}}};
    end else begin : g_full
      assign prio_o[i*8 +: 8] = 8'(prio_q);
    end
  end

  irq_dist_rdmux #(.NUM_IRQ(NUM_IRQ)) u_rd (
    .enable_i  (enable_o),
    .pending_i (pending_o),
    .active_i  (active_o),
    .edge_i    (edge_o),
    .prio_i    (prio_o),
    .region_i  (region),
    .off_i     (off),
    .word_i    (word_i),
    .ok_i      (ok),
    .rdata_o   (rd_comb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_comb;
  end
  assign rdata_o = rdata_q;

  p_rd_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
  p_misalign_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && word_i && addr_i[1:0] != 2'b00) |=> (rdata_o == 32'h0));
endmodule

// File: tb/irq_dist_regbank_tb_top.sv
`timescale 1ns/1ps
module irq_dist_regbank_tb_top;
  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          we = 1'b0, re = 1'b0, word = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  line = '0;
  logic [N-1:0]  enable, pending, active, edge_t;
  logic [N*8-1:0] prio;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_dist_regbank #(.NUM_IRQ(N), .PRIO_BITS(5)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .re_i(re), .addr_i(addr),
    .word_i(word), .wdata_i(wdata), .rdata_o(rdata), .line_i(line),
    .enable_o(enable), .pending_o(pending), .active_o(active),
    .edge_o(edge_t), .prio_o(prio)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic w, input logic [31:0] d);
    we = 1'b1; addr = a; word = w; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic w, output logic [31:0] d);
    re = 1'b1; addr = a; word = w;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R12 enable", enable, 0);
    chk("R12 pending", pending, 0);
    chk("R12 active", active, 0);
    chk("R12 edge", edge_t, 0);
    chk("R12 prio", prio[63:0], 0);
    rd(12'hC08, 1, d); chk("R12 cfg read", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(12'h000, 1, 32'h5);
    chk("R1 set word", enable, 64'h5);
    wr(12'h004, 0, 32'h81);
    chk("R1 byte set irq32/39", enable, 64'h0000_0081_0000_0005);
    rd(12'h084, 1, d); chk("R1 clear view read", d, 32'h81);
    rd(12'h000, 1, d); chk("R1 set view read", d, 32'h5);
    wr(12'h080, 1, 32'h4);
    chk("R2 clear keeps zero bits", enable, 64'h0000_0081_0000_0001);
    rd(12'h080, 1, d); chk("R2 read after clear", d, 32'h1);
  endtask

  task automatic t_config();
    logic [31:0] d;
    wr(12'hC08, 1, 32'h22);
    rd(12'hC08, 1, d); chk("R8 cfg readback", d, 32'h22);
    chk("R8 edge out", edge_t, 64'h0000_0005_0000_0000);
    wr(12'hC00, 1, 32'hFFFF_FFFF);
    rd(12'hC00, 1, d); chk("R8 private locked read", d, 0);
    chk("R8 private stays level", edge_t, 64'h0000_0005_0000_0000);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    line[32] = 1'b1; tick();
    chk("R5 rise sets pending", pending[32], 1);
    line[32] = 1'b0; tick();
    chk("R5 sticky after fall", pending[32], 1);
    rd(12'h104, 1, d); chk("R5 pending read", d, 32'h1);
    wr(12'h184, 1, 32'h1);
    chk("R4 edge clear", pending[32], 0);
  endtask

  task automatic t_level();
    wr(12'h100, 0, 32'h20);
    chk("R3 set latch", pending[5], 1);
    line[5] = 1'b1; tick(); line[5] = 1'b0; tick();
    chk("R3 stays after line drop", pending[5], 1);
    line[5] = 1'b1; tick();
    wr(12'h180, 0, 32'h20);
    chk("R4 level clear follows line high", pending[5], 1);
    line[5] = 1'b0; tick();
    chk("R4 level clear then line low", pending[5], 0);
  endtask

  task automatic t_switch();
    wr(12'h104, 1, 32'h2);
    chk("R3 irq33 latched", pending[33], 1);
    wr(12'hC08, 1, 32'h2A);
    chk("R9 pending kept into edge", pending[33], 1);
    wr(12'h184, 1, 32'h2);
    chk("R9 edge clear", pending[33], 0);
    wr(12'hC08, 1, 32'h22);
    chk("R9 level recompute with latch", pending[33], 1);
    wr(12'h184, 1, 32'h2);
    chk("R9 level clear", pending[33], 0);
  endtask

  task automatic t_active();
    logic [31:0] d;
    wr(12'h205, 0, 32'h01);
    chk("R6 set active", active, 64'h0000_0100_0000_0000);
    wr(12'h205, 0, 32'h01);
    chk("R6 set again no effect", active, 64'h0000_0100_0000_0000);
    rd(12'h204, 1, d); chk("R6 read", d, 32'h100);
    wr(12'h284, 1, 32'h100);
    chk("R6 clear", active, 0);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(12'h400, 1, 32'hFFAB_1234);
    rd(12'h400, 1, d); chk("R7 word read", d, 32'hF8A8_1030);
    chk("R7 prio out", prio[31:0], 32'hF8A8_1030);
    wr(12'h43F, 0, 32'h77);
    rd(12'h43F, 0, d); chk("R7 byte read", d, 32'h70);
    chk("R7 prio out irq63", prio[63*8 +: 8], 8'h70);
  endtask

  task automatic t_range();
    logic [31:0] d;
    wr(12'h008, 1, 32'hFFFF_FFFF);
    chk("R10 enable unchanged", enable, 64'h0000_0081_0000_0001);
    rd(12'h008, 1, d); chk("R10 oor enable read", d, 0);
    wr(12'h440, 1, 32'hFFFF_FFFF);
    rd(12'h440, 1, d); chk("R10 oor prio read", d, 0);
    rd(12'h300, 1, d); chk("R10 unmapped read", d, 0);
    rd(12'hC10, 1, d); chk("R10 oor cfg read", d, 0);
  endtask

  task automatic t_access();
    logic [31:0] d;
    wr(12'h001, 1, 32'hFFFF_FFFF);
    chk("R11 misaligned write ignored", enable, 64'h0000_0081_0000_0001);
    rd(12'h001, 1, d); chk("R11 misaligned read", d, 0);
    rd(12'h000, 0, d); chk("R11 byte read lane0", d, 32'h01);
    re = 1'b1; addr = 12'h084; word = 1'b1;
    #1; chk("R11 no data before edge", rdata, 32'h01);
    @(negedge clk); re = 1'b0;
    chk("R11 data one clock later", rdata, 32'h81);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_enable();
    t_config();
    t_edge();
    t_level();
    t_switch();
    t_active();
    t_prio();
    t_range();
    t_access();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end
endmodule